// File: doc/BRIEF.md
# Interrupt Moderation Threshold Timer

This block coalesces completion interrupts. Instead of forwarding every pending request to the host at once, it counts time ticks and releases the moderated interrupt only when a programmable threshold, given in microseconds, has elapsed. Software programs the threshold and a small control word, and reads back the live count and a sticky status flag that shows the threshold was reached.

Time is counted from one of two strobes. The first is an internal one-microsecond tick. The second is an external tick, used when the control word selects it. The block has two modes. In the per-event mode, counting starts with the first pending request and stops after the release. In the continuous mode, the counter runs all the time and wraps each time it reaches the threshold. When the timer is disabled it does no moderation: the request is passed straight through. Interrupt cause storage is handled outside this block.

Top module: `irq_moderation_timer`

## Requirements
- R1: After reset the threshold reads 300, the count reads 0, the control word reads 0 and `irq_fire` is low.
- R2: A threshold write takes effect on the next clock edge. A value above 5,000,000 is stored as 5,000,000, and any other value is stored unchanged.
- R3: While enable (control bit 0) is 0, `irq_fire` equals `irq_req` in the same cycle, and the count reads 0 from the cycle after enable was seen low.
- R4: Control bit 1 selects the count source. When it is 1, only `ext_tick` advances the count. When it is 0, only `us_tick` advances it.
- R5: In per-event mode (control bit 2 = 0), counting is active during a cycle with `irq_req` high and continues until the release. In the cycle with the threshold-th counted tick, `irq_fire` is high for one cycle if `irq_req` is high. On the next edge the count returns to 0, status bit 4 is set, and counting stops until a new request arrives.
- R6: In continuous mode (control bit 2 = 1), the count advances on every selected tick whether or not a request is pending, and wraps to 0 on the threshold-th tick. That tick sets status bit 4 and raises `irq_fire` only when `irq_req` is high.
- R7: Writing control bit 3 as 1 clears the count, the status bit and any armed request on the next edge, and takes priority over a threshold hit in the same cycle. Bit 3 always reads 0.
- R8: The control word reads bit 0 enable, bit 1 external tick select, bit 2 continuous mode, bit 3 clear (reads 0) and bit 4 reached status. Bit 4 is read-only, so writing it has no effect.
- R9: `cnt_q` shows the number of counted ticks since the last release, wrap or clear.
- R10: A threshold of 0 or 1 makes the first counted tick a threshold hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_wr_en | input | 1 | Threshold write strobe |
| thr_wr_data | input | CNT_W | Threshold value to write, in microseconds |
| ctl_wr_en | input | 1 | Control write strobe |
| ctl_wr_data | input | 5 | Control value to write (layout as in R8) |
| us_tick | input | 1 | Internal one-microsecond strobe |
| ext_tick | input | 1 | External tick strobe |
| irq_req | input | 1 | Pending interrupt request |
| irq_fire | output | 1 | Moderated interrupt release |
| thr_q | output | CNT_W | Stored threshold |
| cnt_q | output | CNT_W | Running count |
| ctl_q | output | 5 | Control word with reached status |

## Verification
Faults in the block's internal state show up quickly at the ports. A count that is not held at zero, or a stuck armed flag, shows on `cnt_q` one edge after the tick that exposes it. A wrong hit comparison moves the cycle of the `irq_fire` pulse by one or more ticks, and also moves the edge on which bit 4 rises. A lost clear leaves bit 4 or a nonzero count visible on the cycle after the write. Threshold saturation is visible on `thr_q` one edge after the write.

// File: rtl/irq_mod_pkg.sv
package irq_mod_pkg;
  localparam int CTL_W     = 5;
  localparam int B_EN      = 0;
  localparam int B_EXT     = 1;
  localparam int B_FOREVER = 2;
  localparam int B_CLR     = 3;
  localparam int B_REACHED = 4;

  typedef struct packed {
    logic forever_mode;
    logic ext_sel;
    logic en;
  } mod_ctl_t;
endpackage

// File: rtl/irq_mod_regs.sv
module irq_mod_regs
  import irq_mod_pkg::*;
#(
  parameter int CNT_W   = 23,
  parameter int THR_MAX = 5000000,
  parameter int THR_RST = 300
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thr_wr_en,
  input  logic [CNT_W-1:0] thr_wr_data,
  input  logic             ctl_wr_en,
  input  logic [CTL_W-1:0] ctl_wr_data,
  output logic [CNT_W-1:0] thr,
  output mod_ctl_t         ctl,
  output logic             clr_pulse
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(THR_MAX);
  localparam logic [CNT_W-1:0] RST_C = CNT_W'(THR_RST);

  logic [CNT_W-1:0] thr_cap;
  assign thr_cap   = (thr_wr_data > MAX_C) ? MAX_C : thr_wr_data;
  assign clr_pulse = ctl_wr_en & ctl_wr_data[B_CLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr <= RST_C;
      ctl <= '0;
    end else begin
      if (thr_wr_en) thr <= thr_cap;
      if (ctl_wr_en) begin
        ctl.en           <= ctl_wr_data[B_EN];
        ctl.ext_sel      <= ctl_wr_data[B_EXT];
        ctl.forever_mode <= ctl_wr_data[B_FOREVER];
      end
    end
  end
endmodule

// File: rtl/irq_mod_tick_sel.sv
module irq_mod_tick_sel (
  input  logic ext_sel,
  input  logic us_tick,
  input  logic ext_tick,
  output logic tick
);
  assign tick = ext_sel ? ext_tick : us_tick;
endmodule

// File: rtl/irq_mod_counter.sv
module irq_mod_counter
  import irq_mod_pkg::*;
#(
  parameter int CNT_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mod_ctl_t         ctl,
  input  logic [CNT_W-1:0] thr,
  input  logic             clr_pulse,
  input  logic             tick,
  input  logic             irq_req,
  output logic [CNT_W-1:0] cnt,
  output logic             reached,
  output logic             fire
);
  logic             armed;
  logic             active;
  logic             hit;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign active  = ctl.en & (ctl.forever_mode | armed | irq_req);
  assign hit     = active & tick & (cnt_inc >= {1'b0, thr});
  assign fire    = ctl.en ? (hit & irq_req) : irq_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      armed   <= 1'b0;
      reached <= 1'b0;
    end else if (clr_pulse) begin
      cnt     <= '0;
      armed   <= 1'b0;
      reached <= 1'b0;
    end else if (!ctl.en) begin
      cnt     <= '0;
      armed   <= 1'b0;
    end else if (hit) begin
      cnt     <= '0;
      armed   <= 1'b0;
      reached <= 1'b1;
    end else if (active) begin
      armed   <= ~ctl.forever_mode;
      if (tick) cnt <= cnt_inc[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/irq_moderation_timer.sv
module irq_moderation_timer
  import irq_mod_pkg::*;
#(
  parameter int CNT_W   = 23,
  parameter int THR_MAX = 5000000,
  parameter int THR_RST = 300
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thr_wr_en,
  input  logic [CNT_W-1:0] thr_wr_data,
  input  logic             ctl_wr_en,
  input  logic [4:0]       ctl_wr_data,
  input  logic             us_tick,
  input  logic             ext_tick,
  input  logic             irq_req,
  output logic             irq_fire,
  output logic [CNT_W-1:0] thr_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [4:0]       ctl_q
);
  mod_ctl_t ctl;
  logic     clr_pulse;
  logic     tick;
  logic     reached;

  irq_mod_regs #(.CNT_W(CNT_W), .THR_MAX(THR_MAX), .THR_RST(THR_RST)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .thr_wr_en(thr_wr_en), .thr_wr_data(thr_wr_data),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .thr(thr_q), .ctl(ctl), .clr_pulse(clr_pulse)
  );

  irq_mod_tick_sel u_tick (
    .ext_sel(ctl.ext_sel), .us_tick(us_tick), .ext_tick(ext_tick), .tick(tick)
  );

  irq_mod_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .thr(thr_q), .clr_pulse(clr_pulse),
    .tick(tick), .irq_req(irq_req), .cnt(cnt_q), .reached(reached), .fire(irq_fire)
  );

  always_comb begin
    ctl_q            = '0;
    ctl_q[B_EN]      = ctl.en;
    ctl_q[B_EXT]     = ctl.ext_sel;
    ctl_q[B_FOREVER] = ctl.forever_mode;
    ctl_q[B_REACHED] = reached;
  end
endmodule

// File: rtl/irq_moderation_timer_chk.sv
module irq_moderation_timer_chk #(
  parameter int CNT_W   = 23,
  parameter int THR_MAX = 5000000,
  parameter int THR_RST = 300
) (
  input logic             clk,
  input logic             rst_n,
  input logic             thr_wr_en,
  input logic [CNT_W-1:0] thr_wr_data,
  input logic             ctl_wr_en,
  input logic [4:0]       ctl_wr_data,
  input logic             us_tick,
  input logic             ext_tick,
  input logic             irq_req,
  input logic             irq_fire,
  input logic [CNT_W-1:0] thr_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [4:0]       ctl_q
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(THR_MAX);

  p_thr_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr_en |=> (thr_q == (($past(thr_wr_data) > MAX_C) ? MAX_C : $past(thr_wr_data))));

  p_off_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[0] |-> (irq_fire == irq_req));

  p_off_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[0] |=> (cnt_q == '0));

  p_hit_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[0] && irq_fire && !(ctl_wr_en && ctl_wr_data[3])) |=> ctl_q[4]);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_en && ctl_wr_data[3]) |=> (cnt_q == '0 && !ctl_q[4]));

  p_clr_reads0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[3]);
endmodule

bind irq_moderation_timer irq_moderation_timer_chk #(
  .CNT_W(CNT_W), .THR_MAX(THR_MAX), .THR_RST(THR_RST)
) u_chk (.*);

// File: tb/test_irq_moderation_timer.sv
module test_irq_moderation_timer;
  localparam int CNT_W = 23;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             thr_wr_en = 1'b0;
  logic [CNT_W-1:0] thr_wr_data = '0;
  logic             ctl_wr_en = 1'b0;
  logic [4:0]       ctl_wr_data = '0;
  logic             us_tick = 1'b0;
  logic             ext_tick = 1'b0;
  logic             irq_req = 1'b0;
  logic             irq_fire;
  logic [CNT_W-1:0] thr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [4:0]       ctl_q;

  int n_chk = 0;
  int n_err = 0;
  int n_cyc = 0;

  always #2 clk = ~clk;

  irq_moderation_timer i_irq_moderation_timer (
    .clk(clk), .rst_n(rst_n), .thr_wr_en(thr_wr_en), .thr_wr_data(thr_wr_data),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .us_tick(us_tick),
    .ext_tick(ext_tick), .irq_req(irq_req), .irq_fire(irq_fire),
    .thr_q(thr_q), .cnt_q(cnt_q), .ctl_q(ctl_q)
  );

  // write value, expected readback
  localparam logic [2*CNT_W-1:0] THR_VEC [7] = '{
    {23'd0,       23'd0},
    {23'd1,       23'd1},
    {23'd300,     23'd300},
    {23'd4999999, 23'd4999999},
    {23'd5000000, 23'd5000000},
    {23'd5000001, 23'd5000000},
    {23'd8388607, 23'd5000000}
  };

  always @(posedge clk) begin
    n_cyc <= n_cyc + 1;
    if (n_cyc > 100000) begin
      n_err = n_err + 1;
      n_chk = n_chk + 1;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_err = n_err + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample fire, pass the posedge, return at negedge
  task automatic cyc(input logic req, input logic us, input logic ex, output logic f);
    irq_req = req; us_tick = us; ext_tick = ex;
    #1 f = irq_fire;
    @(posedge clk); @(negedge clk);
    irq_req = 1'b0; us_tick = 1'b0; ext_tick = 1'b0;
  endtask

  task automatic wr_ctl(input logic [4:0] v);
    ctl_wr_en = 1'b1; ctl_wr_data = v;
    @(posedge clk); @(negedge clk);
    ctl_wr_en = 1'b0;
  endtask

  task automatic wr_thr(input logic [CNT_W-1:0] v);
    thr_wr_en = 1'b1; thr_wr_data = v;
    @(posedge clk); @(negedge clk);
    thr_wr_en = 1'b0;
  endtask

  initial begin
    logic f;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 thr", 32'(thr_q), 300);
    chk("R1 cnt", 32'(cnt_q), 0);
    chk("R1 ctl", 32'(ctl_q), 0);
    #1 chk("R1 fire", 32'(irq_fire), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 saturation table
    for (int i = 0; i < 7; i++) begin
      wr_thr(THR_VEC[i][2*CNT_W-1:CNT_W]);
      chk("R2 thr", 32'(thr_q), 32'(THR_VEC[i][CNT_W-1:0]));
    end
    wr_thr(23'd3);

    // R3 disabled: pass-through, count held
    cyc(1'b1, 1'b1, 1'b0, f); chk("R3 pass hi", 32'(f), 1);
    cyc(1'b0, 1'b1, 1'b0, f); chk("R3 pass lo", 32'(f), 0);
    chk("R3 cnt0", 32'(cnt_q), 0);

    // R5 / R9 per-event mode, threshold 3
    wr_ctl(5'b00001);
    cyc(1'b1, 1'b0, 1'b0, f); chk("R5 no tick no fire", 32'(f), 0);
    chk("R9 cnt no tick", 32'(cnt_q), 0);
    cyc(1'b1, 1'b1, 1'b0, f); chk("R5 t1", 32'(f), 0);
    chk("R9 cnt1", 32'(cnt_q), 1);
    cyc(1'b0, 1'b1, 1'b0, f); chk("R5 armed keeps counting", 32'(cnt_q), 2);
    cyc(1'b1, 1'b1, 1'b0, f); chk("R5 fire on 3rd", 32'(f), 1);
    chk("R5 cnt back to 0", 32'(cnt_q), 0);
    chk("R5 reached", 32'(ctl_q), 32'h11);
    cyc(1'b0, 1'b1, 1'b0, f); cyc(1'b0, 1'b1, 1'b0, f);
    chk("R5 stopped", 32'(cnt_q), 0);
    chk("R5 no fire idle", 32'(f), 0);

    // R7 clear
    cyc(1'b1, 1'b1, 1'b0, f);
    chk("R7 pre cnt", 32'(cnt_q), 1);
    wr_ctl(5'b01001);
    chk("R7 ctl after clear", 32'(ctl_q), 32'h01);
    chk("R7 cnt cleared", 32'(cnt_q), 0);
    cyc(1'b0, 1'b1, 1'b0, f);
    chk("R7 disarmed", 32'(cnt_q), 0);

    // R4 external tick
    wr_ctl(5'b00011);
    cyc(1'b1, 1'b1, 1'b0, f); chk("R4 us ignored", 32'(cnt_q), 0);
    cyc(1'b0, 1'b0, 1'b1, f); chk("R4 ext cnt1", 32'(cnt_q), 1);
    cyc(1'b0, 1'b0, 1'b1, f); chk("R4 ext cnt2", 32'(cnt_q), 2);
    cyc(1'b1, 1'b0, 1'b1, f); chk("R4 ext fire", 32'(f), 1);

    // R6 continuous mode
    wr_ctl(5'b01101);
    cyc(1'b0, 1'b1, 1'b0, f); chk("R6 cnt1", 32'(cnt_q), 1);
    cyc(1'b0, 1'b1, 1'b0, f); chk("R6 cnt2", 32'(cnt_q), 2);
    cyc(1'b0, 1'b1, 1'b0, f); chk("R6 no req no fire", 32'(f), 0);
    chk("R6 wrap", 32'(cnt_q), 0);
    chk("R6 reached", 32'(ctl_q[4]), 1);
    cyc(1'b0, 1'b1, 1'b0, f); cyc(1'b0, 1'b1, 1'b0, f);
    cyc(1'b1, 1'b1, 1'b0, f); chk("R6 fire on wrap", 32'(f), 1);

    // R8 status bit not writable
    wr_ctl(5'b01001);
    wr_ctl(5'b10001);
    chk("R8 bit4 ignored", 32'(ctl_q), 32'h01);

    // R10 thresholds 0 and 1
    wr_thr(23'd0);
    cyc(1'b1, 1'b1, 1'b0, f); chk("R10 thr0", 32'(f), 1);
    wr_thr(23'd1);
    cyc(1'b1, 1'b1, 1'b0, f); chk("R10 thr1", 32'(f), 1);

    // R7 clear beats hit
    ctl_wr_en = 1'b1; ctl_wr_data = 5'b01001;
    cyc(1'b1, 1'b1, 1'b0, f);
    ctl_wr_en = 1'b0;
    chk("R7 clear priority", 32'(ctl_q[4]), 0);

    // R3 disable mid-count
    wr_thr(23'd10);
    cyc(1'b1, 1'b1, 1'b0, f); cyc(1'b1, 1'b1, 1'b0, f);
    chk("R3 pre", 32'(cnt_q), 2);
    wr_ctl(5'b00000);
    @(negedge clk);
    chk("R3 held zero", 32'(cnt_q), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule